// File: doc/BRIEF.md
# Counter-Addressed Serial-Load Latch Bank

This block stores eight single-bit entries. All eight are loaded through one serial data input. A write pointer inside the block selects the entry that receives the next bit, so no address pins are needed. A separate advance input moves the pointer forward. A write strobe copies the data input into the entry the pointer selects. An active-low full flag drops once the strobe is released while the pointer sits on the last entry.

The eight stored bits are read out together on a parallel bus. An active-low output-enable controls that bus and stands for a three-state driver. When the bus is disabled, the block signals this on a bus-valid output and drives zeros.

Everything runs on one system clock. The block registers the advance and strobe inputs and finds their falling edges by comparing each one with its previous sample. Reset is active high. It takes effect as soon as it is asserted, without waiting for a clock. It is released through a two-stage synchronizer, so the block ignores its control inputs for two clocks after reset goes low.

Top module: `serial_latch_bank`

## Requirements
- R1: After reset the pointer is 0, all eight entries read 0, and full_n is 1.
- R2: The pointer advances by one on the clock edge at which adv is sampled low after being sampled high. A rising edge of adv, or adv held at a steady level, leaves the pointer unchanged.
- R3: The pointer wraps from entry 7 to entry 0 on the next advance.
- R4: On each clock edge at which wr_stb is sampled high, entry `ptr` takes the value of ser_d. Entry k is bit k of par_q. The change shows on par_q after that edge, and the other seven entries keep their values.
- R5: While wr_stb is sampled low, no entry changes, whatever ser_d does.
- R6: With oe_n low, par_oe is 1 and par_q shows the entries. With oe_n high, par_oe is 0 and par_q is all zeros. oe_n never changes the stored entries.
- R7: full_n goes to 0 on the clock edge at which wr_stb is sampled low after being sampled high, but only if the pointer is 7 at that edge. Once low it stays low, even after the pointer wraps, until reset.
- R8: Reset forces the pointer to 0 and full_n to 1. A falling edge of adv that arrives during reset has no effect.
- R9: If a write and an advance happen on the same clock edge, the write goes to the entry the pointer held before the advance. The new pointer value applies from the next cycle on.
- R10: Asserting rst clears the entries and sets full_n to 1 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset; takes effect at once, released in sync with clk |
| ser_d | input | 1 | Serial data bit to be written |
| wr_stb | input | 1 | Write strobe; while high, ser_d is written into the selected entry |
| adv | input | 1 | Pointer advance; the pointer steps on each falling edge |
| oe_n | input | 1 | Active-low enable for the parallel output |
| par_q | output | 8 | Stored entries when enabled, zeros otherwise |
| par_oe | output | 1 | High while par_q is being driven |
| full_n | output | 1 | Active-low flag: the last entry has been strobed |

## Verification
On every cycle, the assertions check four things. A pointer step happens only on a detected advance edge, and it wraps at the end. A strobe changes exactly one entry, which then holds the sampled data bit, and no entry moves while the strobe is low. Once full_n has dropped it stays low, and a drop always traces back to a strobe release at the last pointer value.

Some behaviours only the bench scenarios can show, because they need an independent model of the whole bank. These are the complete eight-bit pattern built up over a sequence of writes, an advance that lands on the same edge as a write, an advance held high for several cycles, reset asserted between clock edges, and the disabled bus hiding the contents without changing them.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int unsigned SLB_PTR_W = 3;
  localparam int unsigned SLB_DEPTH = 1 << SLB_PTR_W;

  typedef logic [SLB_PTR_W-1:0] slb_ptr_t;
  typedef logic [SLB_DEPTH-1:0] slb_vec_t;

  function automatic slb_ptr_t slb_step(input slb_ptr_t p);
    return (p == slb_ptr_t'(SLB_DEPTH - 1)) ? '0 : p + slb_ptr_t'(1);
  endfunction

  function automatic slb_vec_t slb_onehot(input slb_ptr_t p);
    slb_vec_t v;
    v = '0;
    v[p] = 1'b1;
    return v;
  endfunction

  function automatic slb_vec_t slb_merge(input slb_vec_t cur, input slb_vec_t sel, input logic d);
    return (cur & ~sel) | (d ? sel : '0);
  endfunction
endpackage

// File: rtl/slb_fall_det.sv
module slb_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  assign fall_o = prev_q & ~sig_i;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);  // R2
endmodule

// File: rtl/slb_ptr.sv
module slb_ptr
  import slb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     adv_fall_i,
  input  logic     stb_fall_i,
  output slb_ptr_t ptr_o,
  output logic     full_n_o
);
  localparam slb_ptr_t LAST = slb_ptr_t'(SLB_DEPTH - 1);

  slb_ptr_t ptr_q;
  logic     full_n_q;
  logic     hit_last;

  assign hit_last = stb_fall_i && (ptr_q == LAST);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ptr_q    <= '0;
      full_n_q <= 1'b1;
    end else begin
      if (adv_fall_i) ptr_q <= slb_step(ptr_q);
      if (hit_last)   full_n_q <= 1'b0;
    end
  end

  assign ptr_o    = ptr_q;
  assign full_n_o = full_n_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    adv_fall_i |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));  // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv_fall_i |=> $stable(ptr_q));  // R2
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    !full_n_q |=> !full_n_q);  // R7
  AST_FULL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(full_n_q) |-> $past(stb_fall_i && ptr_q == LAST));  // R7
endmodule

// File: rtl/slb_store.sv
module slb_store
  import slb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_i,
  input  logic     d_i,
  input  slb_ptr_t ptr_i,
  output slb_vec_t bits_o
);
  slb_vec_t bits_q;
  slb_vec_t sel;

  assign sel = slb_onehot(ptr_i);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       bits_q <= '0;
    else if (wr_i) bits_q <= slb_merge(bits_q, sel, d_i);
  end

  assign bits_o = bits_q;

  AST_SEL_ONE: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == 1);  // R4
  AST_WR_VALUE: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (((bits_q & $past(sel)) != '0) == $past(d_i)));  // R4
  AST_WR_OTHERS: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> ((bits_q & ~$past(sel)) == ($past(bits_q) & ~$past(sel))));  // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(bits_q));  // R5
endmodule

// File: rtl/serial_latch_bank.sv
module serial_latch_bank
  import slb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ser_d,
  input  logic                 wr_stb,
  input  logic                 adv,
  input  logic                 oe_n,
  output logic [SLB_DEPTH-1:0] par_q,
  output logic                 par_oe,
  output logic                 full_n
);
  localparam int unsigned N_CTL = 2;
  localparam int unsigned CTL_ADV = 0;
  localparam int unsigned CTL_STB = 1;

  logic [1:0]       rst_sync;
  logic             irst;
  logic [N_CTL-1:0] ctl_in;
  logic [N_CTL-1:0] ctl_fall;
  slb_ptr_t         ptr;
  slb_vec_t         bits;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) rst_sync <= 2'b11;
    else     rst_sync <= {rst_sync[0], 1'b0};
  end
  assign irst = rst_sync[1];

  assign ctl_in[CTL_ADV] = adv;
  assign ctl_in[CTL_STB] = wr_stb;

  for (genvar g = 0; g < N_CTL; g++) begin : g_edge
    slb_fall_det u_fd (
      .clk    (clk),
      .rst    (irst),
      .sig_i  (ctl_in[g]),
      .fall_o (ctl_fall[g])
    );
  end

  slb_ptr u_ptr (
    .clk        (clk),
    .rst        (irst),
    .adv_fall_i (ctl_fall[CTL_ADV]),
    .stb_fall_i (ctl_fall[CTL_STB]),
    .ptr_o      (ptr),
    .full_n_o   (full_n)
  );

  slb_store u_store (
    .clk    (clk),
    .rst    (irst),
    .wr_i   (wr_stb),
    .d_i    (ser_d),
    .ptr_i  (ptr),
    .bits_o (bits)
  );

  assign par_oe = ~oe_n;
  assign par_q  = oe_n ? '0 : bits;

  AST_RST_CLEAR: assert property (@(posedge clk)
    irst |-> (full_n && bits == '0 && ptr == '0));  // R8
endmodule

// File: tb/sim_serial_latch_bank.sv
module sim_serial_latch_bank;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, ser_d, wr_stb, adv, oe_n;
  logic [7:0] par_q;
  logic       par_oe, full_n;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [7:0] m_bits;
  int         m_ptr;
  logic       m_full_n;

  typedef struct packed {
    logic [7:0] q;
    logic       oe;
    logic       fl;
  } exp_t;
  exp_t  sbq[$];
  string tagq[$];
  event  chk_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_latch_bank u0 (
    .clk(clk), .rst(rst), .ser_d(ser_d), .wr_stb(wr_stb), .adv(adv),
    .oe_n(oe_n), .par_q(par_q), .par_oe(par_oe), .full_n(full_n)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_now(input string tag, input logic [7:0] q, input logic oe, input logic fl);
    exp_t e;
    e.q = q; e.oe = oe; e.fl = fl;
    sbq.push_back(e);
    tagq.push_back(tag);
    -> chk_ev;
    #1;
  endtask

  task automatic expect_model(input string tag);
    expect_now(tag, m_bits, 1'b1, m_full_n);
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      while (sbq.size() > 0) begin
        exp_t  e;
        string t;
        e = sbq.pop_front();
        t = tagq.pop_front();
        n_checks++;
        if (par_q !== e.q || par_oe !== e.oe || full_n !== e.fl) begin
          n_errors++;
          $display("FAIL %s: got q=%b oe=%b full_n=%b, expected q=%b oe=%b full_n=%b",
                   t, par_q, par_oe, full_n, e.q, e.oe, e.fl);
        end
      end
    end
  end

  task automatic write_bit(input logic d);
    ser_d = d; wr_stb = 1'b1;
    tick();
    m_bits[m_ptr] = d;
    wr_stb = 1'b0;
    tick();
    if (m_ptr == 7) m_full_n = 1'b0;
  endtask

  task automatic advance();
    adv = 1'b1;
    tick();
    adv = 1'b0;
    tick();
    m_ptr = (m_ptr + 1) % 8;
  endtask

  task automatic write_and_adv(input logic d);
    adv = 1'b1;
    tick();
    ser_d = d; wr_stb = 1'b1; adv = 1'b0;
    tick();
    m_bits[m_ptr] = d;
    m_ptr = (m_ptr + 1) % 8;
    wr_stb = 1'b0;
    tick();
    if (m_ptr == 7) m_full_n = 1'b0;
  endtask

  task automatic model_reset();
    m_bits = '0; m_ptr = 0; m_full_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : driver
    logic [7:0] pat;
    rst = 1'b1; ser_d = 1'b0; wr_stb = 1'b0; adv = 1'b0; oe_n = 1'b0;
    model_reset();
    repeat (3) tick();
    rst = 1'b0;
    repeat (3) tick();
    expect_model("R1 reset state");

    // R4 R7: fill all entries with a pattern
    pat = 8'b1011_0011;
    for (int i = 0; i < 8; i++) begin
      write_bit(pat[i]);
      expect_model(i == 7 ? "R7 full after last entry" : "R4 serial write");
      if (i < 7) advance();
    end

    // R6: disabled bus hides contents without altering them
    oe_n = 1'b1;
    tick();
    expect_now("R6 bus disabled", 8'h00, 1'b0, m_full_n);
    oe_n = 1'b0;
    tick();
    expect_model("R6 contents kept");

    // R5: strobe low, data toggling
    for (int i = 0; i < 6; i++) begin
      ser_d = ~ser_d;
      tick();
    end
    expect_model("R5 no write while strobe low");

    // R2 R3: held-high advance counts once, wraps 7 -> 0
    adv = 1'b1;
    repeat (4) tick();
    adv = 1'b0;
    tick();
    m_ptr = (m_ptr + 1) % 8;
    repeat (3) tick();
    write_bit(1'b0);
    expect_model("R3 wrap to entry 0, R7 full stays low");

    // R2: rising edge and high level do not advance
    adv = 1'b1;
    tick();
    tick();
    write_bit(1'b1);
    expect_model("R2 rising edge no advance");
    adv = 1'b0;
    tick();
    m_ptr = (m_ptr + 1) % 8;
    write_bit(1'b0);
    expect_model("R2 falling edge advances once");

    // R10 R8: reset asserted between edges, advance falling during reset
    @(posedge clk);
    #2;
    rst = 1'b1; adv = 1'b1;
    #1;
    model_reset();
    expect_model("R10 immediate clear on reset");
    tick();
    adv = 1'b0;
    repeat (2) tick();
    rst = 1'b0;
    repeat (3) tick();
    write_bit(1'b1);
    expect_model("R8 pointer at zero after reset");

    // R9: write and advance on the same edge
    repeat (5) advance();
    write_and_adv(1'b1);
    expect_model("R9 write uses old pointer");
    write_and_adv(1'b1);
    expect_model("R9 R7 full from new pointer");
    write_bit(1'b0);
    expect_model("R9 pointer applied next cycle");

    done = 1'b1;
    #1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule